// File: doc/BRIEF.md
# Reversible-Gate Decimal Digit Adder

This block adds two binary-coded decimal digits and a carry-in, and returns one corrected decimal digit and a decimal carry-out. It is purely combinational: the outputs settle within the same cycle as the inputs. It fits into a wider decimal datapath, where several instances are chained through their decimal carries.

Every part of the netlist is a reversible primitive. Each 3-input gate has three outputs, and each line drives exactly one gate input or one port. The only place a value is duplicated is a 2-input copy gate that maps (A, B) to (A, A XOR B), with B tied low. Each gate output that feeds no later gate and is not a result goes to a garbage port, so the gate budget and garbage budget can be checked at the boundary.

There are three stages:
- A ripple of four reversible full adders forms the binary sum.
- A three-gate detector raises the correction flag when the binary sum is above nine.
- A four-gate stage adds six to the binary sum when the flag is set.

The totals are 16 gates and 15 garbage bits.

Top module: `rvbcd_digit_add`

## Requirements
- R1: For operands 0 to 9 and either carry-in, `sum_dig` equals (a + b + cin) mod 10. With all inputs zero, every output, including all garbage bits, is zero.
- R2: For operands 0 to 9, `carry_out` is 1 exactly when a + b + cin is 10 or more.
- R3: Each full-adder cell i (0 to 3) is two Toffoli-style gates, each mapping (A,B,C) to (A, A^B, (A&B)^C). The cell's two garbage bits are `junk_bits[2i]` = a[i] and `junk_bits[2i+1]` = a[i]^b[i].
- R4: The detector computes flag X = C4 | (S3 & (S1 | S2)), where C4 and S3..S0 are the binary carry and binary sum. It uses three gates. Its garbage is `junk_bits[8]` = S3^(S1|S2), `junk_bits[9]` = S3&(S1|S2) and `junk_bits[10]` = C4.
- R5: The plus-six stage outputs S3..S0 plus 0110 modulo 16 when X is 1, and S3..S0 unchanged when X is 0. Its garbage is:
  - `junk_bits[11]` = X
  - `junk_bits[12]` = X^S2
  - `junk_bits[13]` = c3, the carry into bit 3, equal to bit 3 of (S2..S0 + (X ? 6 : 0))
  - `junk_bits[14]` = c3&S3, the discarded carry out of bit 3
- R6: Operands 5 and 5 with carry-in 0 give `sum_dig` = 0000 and `carry_out` = 1.
- R7: One copy gate duplicates X. One copy drives `carry_out` and the other drives the plus-six stage, so for valid operands `carry_out` equals the R4 flag and the garbage bit `junk_bits[11]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dig_a | input | 4 | First decimal digit operand |
| dig_b | input | 4 | Second decimal digit operand |
| carry_in | input | 1 | Decimal carry from the digit below |
| sum_dig | output | 4 | Corrected decimal sum digit |
| carry_out | output | 1 | Decimal carry to the digit above |
| junk_bits | output | 15 | Unused gate outputs, laid out as in R3 to R5 |

## Verification
The bench builds the block with its default digit width of four bits, the only width for which the decimal correction is defined. This keeps the operand space small enough to visit every valid operand pair with both carry-in values. The sweep therefore covers every binary sum from 0 to 19: the pass-through region, sums 10 to 15 where the flag comes from the sum bits, and sums 16 to 19 where it comes from the binary carry. For each combination, all fifteen garbage bits are compared against values derived arithmetically from the operands.

// File: rtl/rvbcd_pkg.sv
package rvbcd_pkg;
    // width of one decimal digit in binary
    localparam int DIGIT_W    = 4;
    // garbage outputs left by each stage
    localparam int FA_JUNK    = 2;
    localparam int DET_JUNK   = 3;
    localparam int FIX_JUNK   = 4;
    localparam int ADD_JUNK   = DIGIT_W * FA_JUNK;
    localparam int JUNK_W     = ADD_JUNK + DET_JUNK + FIX_JUNK;
    // offsets of each stage's garbage inside the garbage port
    localparam int DET_BASE   = ADD_JUNK;
    localparam int FIX_BASE   = ADD_JUNK + DET_JUNK;
    // gate budget: two per full adder, three detector, one copy, four fix
    localparam int GATE_COUNT = DIGIT_W * 2 + 3 + 1 + 4;
    // largest legal decimal digit and the correction constant
    localparam int DIGIT_MAX  = 9;
    localparam int FIX_ADD    = 6;

    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/rv_tof3.sv
// Toffoli-style 3-in/3-out primitive: (A,B,C) -> (A, A^B, (A&B)^C)
module rv_tof3 (
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    output logic out_p,
    output logic out_q,
    output logic out_r
);
    assign out_p = in_a;
    assign out_q = in_a ^ in_b;
    assign out_r = (in_a & in_b) ^ in_c;
endmodule

// File: rtl/rv_orx3.sv
// OR-accumulate 3-in/3-out primitive: (A,B,C) -> (A, B, (A|B)^C)
module rv_orx3 (
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    output logic out_p,
    output logic out_q,
    output logic out_r
);
    assign out_p = in_a;
    assign out_q = in_b;
    assign out_r = (in_a | in_b) ^ in_c;
endmodule

// File: rtl/rv_copy2.sv
// Copy primitive: (A,B) -> (A, A^B); with B low it yields two copies of A
module rv_copy2 (
    input  logic in_a,
    input  logic in_b,
    output logic out_p,
    output logic out_q
);
    assign out_p = in_a;
    assign out_q = in_a ^ in_b;

    always_comb begin
        // R7
        cpy_match_chk: assert (in_b || (out_p == out_q));
    end
endmodule

// File: rtl/rv_full_add.sv
// Reversible full adder from two Toffoli-style gates, two garbage lines
module rv_full_add (
    input  logic       op_a,
    input  logic       op_b,
    input  logic       c_in,
    output logic       sum_o,
    output logic       c_out,
    output logic [1:0] junk
);
    logic g1_q;
    logic g1_r;

    // first gate: (a, b, 0) -> (a, a^b, a&b)
    rv_tof3 u_half (
        .in_a  (op_a),
        .in_b  (op_b),
        .in_c  (1'b0),
        .out_p (junk[0]),
        .out_q (g1_q),
        .out_r (g1_r)
    );

    // second gate: (a^b, cin, a&b) -> (a^b, sum, carry)
    rv_tof3 u_join (
        .in_a  (g1_q),
        .in_b  (c_in),
        .in_c  (g1_r),
        .out_p (junk[1]),
        .out_q (sum_o),
        .out_r (c_out)
    );

    always_comb begin
        // R3
        fa_total_chk: assert ({c_out, sum_o} == (2'(op_a) + 2'(op_b) + 2'(c_in)));
    end
endmodule

// File: rtl/rvbcd_detect.sv
// Three-gate detector of a binary sum above nine; sum bits pass through
module rvbcd_detect
    import rvbcd_pkg::*;
(
    input  logic                s1_i,
    input  logic                s2_i,
    input  logic                s3_i,
    input  logic                c4_i,
    output logic                s1_o,
    output logic                s2_o,
    output logic                s3_o,
    output logic                flag_o,
    output logic [DET_JUNK-1:0] junk
);
    logic any12;
    logic hi_and;

    // (S1, S2, 0) -> (S1, S2, S1|S2)
    rv_orx3 u_or12 (
        .in_a  (s1_i),
        .in_b  (s2_i),
        .in_c  (1'b0),
        .out_p (s1_o),
        .out_q (s2_o),
        .out_r (any12)
    );

    // (S3, S1|S2, 0) -> (S3, S3^(S1|S2), S3&(S1|S2))
    rv_tof3 u_and3 (
        .in_a  (s3_i),
        .in_b  (any12),
        .in_c  (1'b0),
        .out_p (s3_o),
        .out_q (junk[0]),
        .out_r (hi_and)
    );

    // (S3&(S1|S2), C4, 0) -> (.., C4, X)
    rv_orx3 u_orc4 (
        .in_a  (hi_and),
        .in_b  (c4_i),
        .in_c  (1'b0),
        .out_p (junk[1]),
        .out_q (junk[2]),
        .out_r (flag_o)
    );

    always_comb begin
        // R4
        det_carry_chk: assert (!c4_i || flag_o);
        // R4
        det_low_chk: assert (flag_o || !(s3_i && (s1_i || s2_i)));
    end
endmodule

// File: rtl/rvbcd_fix6.sv
// Four-gate stage that adds 0110 under the flag, dropping the top carry
module rvbcd_fix6
    import rvbcd_pkg::*;
(
    input  digit_t              bin_s,
    input  logic                flag_i,
    output digit_t              dec_s,
    output logic [FIX_JUNK-1:0] junk
);
    logic flag_k;
    logic c2;
    logic x2_q;
    logic x2_r;
    logic c3;

    assign dec_s[0] = bin_s[0];

    // bit 1: (X, S1, 0) -> (X, X^S1, X&S1)
    rv_tof3 u_b1 (
        .in_a  (flag_i),
        .in_b  (bin_s[1]),
        .in_c  (1'b0),
        .out_p (flag_k),
        .out_q (dec_s[1]),
        .out_r (c2)
    );

    // bit 2 half: (X, S2, 0) -> (X, X^S2, X&S2)
    rv_tof3 u_b2h (
        .in_a  (flag_k),
        .in_b  (bin_s[2]),
        .in_c  (1'b0),
        .out_p (junk[0]),
        .out_q (x2_q),
        .out_r (x2_r)
    );

    // bit 2 join: (X^S2, c2, X&S2) -> (X^S2, sum2, c3)
    rv_tof3 u_b2j (
        .in_a  (x2_q),
        .in_b  (c2),
        .in_c  (x2_r),
        .out_p (junk[1]),
        .out_q (dec_s[2]),
        .out_r (c3)
    );

    // bit 3: (c3, S3, 0) -> (c3, sum3, dropped carry)
    rv_tof3 u_b3 (
        .in_a  (c3),
        .in_b  (bin_s[3]),
        .in_c  (1'b0),
        .out_p (junk[2]),
        .out_q (dec_s[3]),
        .out_r (junk[3])
    );

    always_comb begin
        // R5
        fix_wrap_chk: assert (dec_s == DIGIT_W'(bin_s + (flag_i ? DIGIT_W'(FIX_ADD) : '0)));
    end
endmodule

// File: rtl/rvbcd_digit_add.sv
// Decimal digit adder netlisted from reversible primitives
module rvbcd_digit_add
    import rvbcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] dig_a,
    input  logic [DIGIT_W-1:0] dig_b,
    input  logic               carry_in,
    output logic [DIGIT_W-1:0] sum_dig,
    output logic               carry_out,
    output logic [JUNK_W-1:0]  junk_bits
);
    // ripple carries through the binary adder, index DIGIT_W is C4
    logic [DIGIT_W:0] rip;
    digit_t           bin_s;
    digit_t           pass_s;
    logic             flag_raw;
    logic             flag_fix;

    assign rip[0] = carry_in;

    genvar gi;
    generate
        for (gi = 0; gi < DIGIT_W; gi++) begin : g_fa
            rv_full_add u_fa (
                .op_a  (dig_a[gi]),
                .op_b  (dig_b[gi]),
                .c_in  (rip[gi]),
                .sum_o (bin_s[gi]),
                .c_out (rip[gi+1]),
                .junk  (junk_bits[gi*FA_JUNK +: FA_JUNK])
            );
        end
    endgenerate

    // S0 is not inspected by the detector and goes straight on
    assign pass_s[0] = bin_s[0];

    rvbcd_detect u_det (
        .s1_i   (bin_s[1]),
        .s2_i   (bin_s[2]),
        .s3_i   (bin_s[3]),
        .c4_i   (rip[DIGIT_W]),
        .s1_o   (pass_s[1]),
        .s2_o   (pass_s[2]),
        .s3_o   (pass_s[3]),
        .flag_o (flag_raw),
        .junk   (junk_bits[DET_BASE +: DET_JUNK])
    );

    // single copy gate: one copy leaves as the decimal carry
    rv_copy2 u_copy (
        .in_a  (flag_raw),
        .in_b  (1'b0),
        .out_p (carry_out),
        .out_q (flag_fix)
    );

    rvbcd_fix6 u_fix (
        .bin_s  (pass_s),
        .flag_i (flag_fix),
        .dec_s  (sum_dig),
        .junk   (junk_bits[FIX_BASE +: FIX_JUNK])
    );

    always_comb begin
        // R1
        sum_range_chk: assert (!(dig_a <= DIGIT_W'(DIGIT_MAX) && dig_b <= DIGIT_W'(DIGIT_MAX))
                               || sum_dig <= DIGIT_W'(DIGIT_MAX));
        // R2
        carry_val_chk: assert (!(dig_a <= DIGIT_W'(DIGIT_MAX) && dig_b <= DIGIT_W'(DIGIT_MAX))
                               || (carry_out == ({rip[DIGIT_W], bin_s} > (DIGIT_W+1)'(DIGIT_MAX))));
    end
endmodule

// File: tb/rvbcd_digit_add_bench.sv
`timescale 1ns/1ps
module rvbcd_digit_add_bench;
    logic        clk;
    logic        rst;
    logic [3:0]  dig_a;
    logic [3:0]  dig_b;
    logic        carry_in;
    logic [3:0]  sum_dig;
    logic        carry_out;
    logic [14:0] junk_bits;

    int n_cmp;
    int n_bad;
    bit done;

    rvbcd_digit_add u_rvbcd_digit_add (
        .dig_a     (dig_a),
        .dig_b     (dig_b),
        .carry_in  (carry_in),
        .sum_dig   (sum_dig),
        .carry_out (carry_out),
        .junk_bits (junk_bits)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0h expected=%0h",
                     req, dig_a, dig_b, carry_in, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

    initial begin
        n_cmp = 0;
        n_bad = 0;
        done  = 0;
        rst   = 1'b1;
        dig_a = '0;
        dig_b = '0;
        carry_in = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle all-zero inputs give all-zero outputs and garbage
        check("R1 idle sum", int'(sum_dig), 0);
        check("R1 idle carry", int'(carry_out), 0);
        check("R1 idle junk", int'(junk_bits), 0);

        // R6: five plus five
        @(posedge clk); #1;
        dig_a = 4'd5; dig_b = 4'd5; carry_in = 1'b0;
        @(negedge clk);
        check("R6 sum", int'(sum_dig), 0);
        check("R6 carry", int'(carry_out), 1);

        for (int ci = 0; ci < 2; ci++) begin
            for (int a = 0; a < 10; a++) begin
                for (int b = 0; b < 10; b++) begin
                    int tot, s, c4, x, add6, c3, topc;
                    int exp_junk;
                    @(posedge clk); #1;
                    dig_a = 4'(a); dig_b = 4'(b); carry_in = 1'(ci);
                    @(negedge clk);
                    tot  = a + b + ci;
                    s    = tot % 16;
                    c4   = tot / 16;
                    x    = (tot >= 10) ? 1 : 0;
                    add6 = x * 6;
                    c3   = (((s % 8) + add6) / 8) % 2;
                    topc = ((s + add6) / 16) % 2;
                    // R1 and R2
                    check("R1 sum", int'(sum_dig), tot % 10);
                    check("R2 carry", int'(carry_out), tot / 10);
                    // R3: full-adder garbage
                    exp_junk = 0;
                    for (int i = 0; i < 4; i++) begin
                        int ai, bi;
                        ai = (a >> i) & 1;
                        bi = (b >> i) & 1;
                        exp_junk = exp_junk | (ai << (2 * i)) | ((ai ^ bi) << (2 * i + 1));
                    end
                    check("R3 fa junk", int'(junk_bits[7:0]), exp_junk);
                    // R4: detector garbage
                    begin
                        int s1, s2, s3, o12;
                        s1 = (s >> 1) & 1;
                        s2 = (s >> 2) & 1;
                        s3 = (s >> 3) & 1;
                        o12 = s1 | s2;
                        check("R4 det junk", int'(junk_bits[10:8]),
                              (s3 ^ o12) | ((s3 & o12) << 1) | (c4 << 2));
                        // R5: correction garbage
                        check("R5 fix junk", int'(junk_bits[14:11]),
                              x | ((x ^ s2) << 1) | (c3 << 2) | (topc << 3));
                    end
                    // R7: copy of the flag matches the carry-out
                    check("R7 copy", int'(junk_bits[11]), int'(carry_out));
                    // R5: corrected digit versus binary sum plus six
                    check("R5 fix value", int'(sum_dig), (s + add6) % 16);
                end
            end
        end
        done = 1;
        summary();
    end
endmodule